// File: doc/BRIEF.md
# Pulse-Width and Hit Counter Engine

This engine watches one comparator output that is not related to any clock. It measures how long each pulse stays high, in cycles of a fast sampling clock. With a 200 MHz clock, one count is a 5 ns bin. It also keeps a running count of pulses. The comparator level first passes through a chain of synchronizing flops. Rising and falling edges are then found on the synchronized level.

The width counter is controlled by a state machine with three states. The states are `W_IDLE` (no pulse), `W_COUNT` (pulse open, counting) and `W_CLIP` (pulse open, counter pinned at its maximum). The transitions are:

- rise-open: `W_IDLE` to `W_COUNT` on a rising edge.
- clip: `W_COUNT` to `W_CLIP` when the next increment reaches all ones.
- close: `W_COUNT` or `W_CLIP` to `W_IDLE` on a falling edge.

A close ends the pulse. It produces one word that holds the width in the upper half and the hit count in the lower half.

An output holding stage passes this word on through a valid/ready handshake toward a FIFO. It has two states, `O_EMPTY` and `O_HOLD`, and these transitions:

- capture: `O_EMPTY` to `O_HOLD` when a pulse closes.
- drain: `O_HOLD` to `O_EMPTY` when the word is taken and no new pulse closes.
- refill: stays in `O_HOLD` when the word is taken in the same cycle a pulse closes.
- stall: stays in `O_HOLD` while ready is low.

Top module: `tot_hit_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the engine clears `word_valid`, the hit count and the width measurement. `word_valid` is low after that edge. The first pulse after reset reports hit count 1.
- R2: The width field `word_data[WIDTH_W+HIT_W-1:HIT_W]` equals the number of clock edges at which `comp_in` was sampled high. The word becomes valid after the second clock edge following the first edge that samples `comp_in` low again (with `SYNC_STAGES`=2).
- R3: A pulse longer than 2^WIDTH_W-1 cycles reports a width of all ones; the field never wraps.
- R4: A pulse sampled high at exactly one edge reports width 1. A reported width is never zero.
- R5: The hit field `word_data[HIT_W-1:0]` increases by one for each pulse, counted at its rising edge. It includes the pulse that the word describes.
- R6: The hit count wraps from all ones to zero.
- R7: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` does not change.
- R8: A pulse that ends while a word is held with `word_ready` low is still counted in the hit count. Its own word is discarded.
- R9: A word is taken at an edge where `word_valid` and `word_ready` are both high. If a pulse closes at that same edge, its word is valid right after the edge with no empty cycle. Otherwise `word_valid` drops.

Parameters: `WIDTH_W` (default 16), `HIT_W` (default 16), `SYNC_STAGES` (default 2, at least 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_in | input | 1 | Asynchronous comparator level |
| word_ready | input | 1 | Downstream can take a word |
| word_valid | output | 1 | A word is on `word_data` |
| word_data | output | WIDTH_W+HIT_W | Width in upper half, hit count in lower half |

## Verification
Two functions can meet in the same cycle: a held word being taken, and the close of a newer pulse. When both fall on one edge, the new word must replace the old one with no empty cycle. When the close meets a stalled word instead, the new word must be dropped while its hit still counts. The bench provokes both cases by running a train of short pulses, one to three cycles wide, against a ready pattern that changes every cycle. A behavioural model predicts the exact state of `word_valid` and `word_data` after every edge, and each cycle is judged against it. A separate stall sequence checks that a dropped pulse leaves a gap of one in the hit numbers of the next word taken.

// File: rtl/tot_pkg.sv
package tot_pkg;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_COUNT = 2'd1,
        W_CLIP  = 2'd2
    } width_state_t;

    typedef enum logic {
        O_EMPTY = 1'b0,
        O_HOLD  = 1'b1
    } out_state_t;

endpackage

// File: rtl/tot_sync.sv
module tot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] taps;

    // taps[STAGES-1] is the synchronized level, taps[STAGES] its previous value
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps <= {taps[TAPS-2:0], din};
        end
    end

    assign level = taps[STAGES-1];
    assign rise  = taps[STAGES-1] & ~taps[STAGES];
    assign fall  = ~taps[STAGES-1] & taps[STAGES];

endmodule

// File: rtl/tot_width_ctr.sv
module tot_width_ctr
    import tot_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         level,
    input  logic         rise,
    input  logic         fall,
    output logic         done,
    output logic [W-1:0] width
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    width_state_t state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            W_IDLE: begin
                if (rise) begin
                    state_d = W_COUNT;
                    cnt_d   = ONE;
                end
            end
            W_COUNT: begin
                if (fall) begin
                    state_d = W_IDLE;
                end else if (level) begin
                    if (cnt_q == MAXV - ONE) begin
                        state_d = W_CLIP;
                    end
                    cnt_d = cnt_q + ONE;
                end
            end
            W_CLIP: begin
                if (fall) begin
                    state_d = W_IDLE;
                end
            end
            default: begin
                state_d = W_IDLE;
            end
        endcase
    end

    always_comb begin
        done  = fall && (state_q != W_IDLE);
        width = cnt_q;
    end

endmodule

// File: rtl/tot_hit_ctr.sv
module tot_hit_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (rise) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/tot_out_stage.sv
module tot_out_stage
    import tot_pkg::*;
#(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [WW-1:0] load_word,
    input  logic          ready,
    output logic          valid,
    output logic [WW-1:0] word
);
    out_state_t    state_q, state_d;
    logic [WW-1:0] word_q, word_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= O_EMPTY;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        unique case (state_q)
            O_EMPTY: begin
                if (load) begin
                    state_d = O_HOLD;
                    word_d  = load_word;
                end
            end
            O_HOLD: begin
                if (ready) begin
                    if (load) begin
                        word_d = load_word;
                    end else begin
                        state_d = O_EMPTY;
                    end
                end
            end
            default: begin
                state_d = O_EMPTY;
            end
        endcase
    end

    always_comb begin
        valid = (state_q == O_HOLD);
        word  = word_q;
    end

endmodule

// File: rtl/tot_hit_engine.sv
module tot_hit_engine #(
    parameter int WIDTH_W     = 16,
    parameter int HIT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     comp_in,
    input  logic                     word_ready,
    output logic                     word_valid,
    output logic [WIDTH_W+HIT_W-1:0] word_data
);
    localparam int WORD_W = WIDTH_W + HIT_W;

    logic               sync_level;
    logic               sync_rise;
    logic               sync_fall;
    logic               pulse_done;
    logic [WIDTH_W-1:0] pulse_width;
    logic [HIT_W-1:0]   hit_count;
    logic [WORD_W-1:0]  packed_word;

    tot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (comp_in),
        .level (sync_level),
        .rise  (sync_rise),
        .fall  (sync_fall)
    );

    tot_width_ctr #(.W(WIDTH_W)) u_width (
        .clk   (clk),
        .rst   (rst),
        .level (sync_level),
        .rise  (sync_rise),
        .fall  (sync_fall),
        .done  (pulse_done),
        .width (pulse_width)
    );

    tot_hit_ctr #(.W(HIT_W)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .rise  (sync_rise),
        .count (hit_count)
    );

    assign packed_word = {pulse_width, hit_count};

    tot_out_stage #(.WW(WORD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (pulse_done),
        .load_word (packed_word),
        .ready     (word_ready),
        .valid     (word_valid),
        .word      (word_data)
    );

endmodule

// File: rtl/tot_hit_engine_chk.sv
module tot_hit_engine_chk #(
    parameter int WIDTH_W = 16,
    parameter int HIT_W   = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     word_ready,
    input logic                     word_valid,
    input logic [WIDTH_W+HIT_W-1:0] word_data,
    input logic                     pulse_done,
    input logic [WIDTH_W-1:0]       pulse_width,
    input logic                     hit_rise,
    input logic [HIT_W-1:0]         hit_count
);
    // R1
    reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !word_valid);

    // R7
    stall_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    // R4
    no_zero_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_done |-> (pulse_width != '0));

    // R9
    refill_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_done && (!word_valid || word_ready)) |=> word_valid);

    // R6
    hit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_rise && (hit_count == '1)) |=> (hit_count == '0));

    // R5
    hit_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_rise |=> $stable(hit_count));

endmodule

bind tot_hit_engine tot_hit_engine_chk #(
    .WIDTH_W (WIDTH_W),
    .HIT_W   (HIT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .word_ready  (word_ready),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .pulse_done  (pulse_done),
    .pulse_width (pulse_width),
    .hit_rise    (sync_rise),
    .hit_count   (hit_count)
);

// File: tb/tot_hit_engine_tb.sv
module tot_hit_engine_tb;
    localparam int WW  = 8;
    localparam int HW  = 8;
    localparam int TW  = WW + HW;
    localparam int WMAX = (1 << WW) - 1;
    localparam int HMOD = 1 << HW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          comp_in = 1'b0;
    logic          word_ready = 1'b1;
    logic          word_valid;
    logic [TW-1:0] word_data;

    int compared = 0;
    int mismatched = 0;
    bit checking = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_s1 = 0, m_s2 = 0, m_s3 = 0;
    int m_len = 0, m_hits = 0, m_valid = 0, m_word = 0, m_dropped = 0;
    int acc_q[$];

    tot_hit_engine #(.WIDTH_W(WW), .HIT_W(HW), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .comp_in    (comp_in),
        .word_ready (word_ready),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        int lv, pv, ld, w;
        if (word_valid === 1'b1 && word_ready === 1'b1 && !rst) acc_q.push_back(int'(word_data));
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_len = 0; m_hits = 0; m_valid = 0; m_word = 0;
        end else begin
            lv = m_s2; pv = m_s3;
            ld = 0;
            if (!lv && pv) begin
                ld = (!m_valid || word_ready) ? 1 : 0;
                if (!ld) m_dropped++;
            end
            if (m_valid && word_ready) m_valid = 0;
            if (ld) begin
                w = (m_len > WMAX) ? WMAX : m_len;
                m_word = (w << HW) | m_hits;
                m_valid = 1;
            end
            if (lv && !pv) begin
                m_len = 1;
                m_hits = (m_hits + 1) % HMOD;
            end else if (lv) begin
                m_len++;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(comp_in);
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            compared++;
            if (word_valid !== 1'(m_valid) ||
                (m_valid != 0 && word_data !== TW'(m_word))) begin
                mismatched++;
                $display("FAIL %s cycle compare: valid=%0b data=%h expected valid=%0d data=%h",
                         cur_req, word_valid, word_data, m_valid, TW'(m_word));
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int hi, input int lo);
        comp_in = 1'b1;
        repeat (hi) @(negedge clk);
        comp_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    function automatic int wfield(input int wd);
        return (wd >> HW) & WMAX;
    endfunction

    function automatic int hfield(input int wd);
        return wd % HMOD;
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int base, h;
        int widths[4] = '{3, 7, 1, 12};
        bit saw_zero;
        @(negedge clk);
        repeat (3) @(negedge clk);
        checking = 1;
        // R1: state after reset
        check(word_valid === 1'b0, "R1 valid after reset", int'(word_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2 R4 R5: assorted widths, ready always high
        cur_req = "R2";
        base = acc_q.size();
        foreach (widths[i]) pulse(widths[i], 5);
        repeat (4) @(negedge clk);
        check(acc_q.size() == base + 4, "R2 word count", acc_q.size() - base, 4);
        foreach (widths[i]) begin
            if (acc_q.size() > base + i) begin
                check(wfield(acc_q[base+i]) == widths[i], "R2 width", wfield(acc_q[base+i]), widths[i]);
                check(hfield(acc_q[base+i]) == i + 1, "R5 hit count", hfield(acc_q[base+i]), i + 1);
            end
        end
        if (acc_q.size() > base + 2)
            check(wfield(acc_q[base+2]) == 1, "R4 single-cycle width", wfield(acc_q[base+2]), 1);

        // R3: saturation
        cur_req = "R3";
        pulse(300, 6);
        check(wfield(acc_q[$]) == WMAX, "R3 saturated width", wfield(acc_q[$]), WMAX);

        // R7 R8: stall, drop while held
        cur_req = "R7";
        word_ready = 1'b0;
        h = hfield(acc_q[$]);
        base = acc_q.size();
        pulse(5, 4);
        pulse(4, 6);
        check(word_valid === 1'b1, "R7 valid held", int'(word_valid), 1);
        check(wfield(int'(word_data)) == 5, "R7 held word width", wfield(int'(word_data)), 5);
        check(m_dropped == 1, "R8 dropped pulses", m_dropped, 1);
        word_ready = 1'b1;
        cur_req = "R8";
        repeat (2) @(negedge clk);
        check(acc_q.size() == base + 1, "R8 only held word taken", acc_q.size() - base, 1);
        pulse(2, 6);
        check(hfield(acc_q[$]) == (h + 3) % HMOD, "R8 hit skips dropped", hfield(acc_q[$]), (h + 3) % HMOD);
        check(wfield(acc_q[$]) == 2, "R8 width after drop", wfield(acc_q[$]), 2);

        // R9: short pulses against a changing ready
        cur_req = "R9";
        fork
            begin
                for (int i = 0; i < 40; i++) pulse(1 + i % 3, 1 + i % 2);
            end
            begin
                for (int k = 0; k < 140; k++) begin
                    word_ready = ((k * 7) % 5) < 3;
                    @(negedge clk);
                end
            end
        join
        word_ready = 1'b1;
        repeat (6) @(negedge clk);
        check(word_valid === 1'b0, "R9 drained", int'(word_valid), 0);

        // R6: wrap of the hit count
        cur_req = "R6";
        base = acc_q.size();
        for (int i = 0; i < 260; i++) pulse(1, 2);
        repeat (4) @(negedge clk);
        saw_zero = 0;
        for (int i = base; i < acc_q.size(); i++) if (hfield(acc_q[i]) == 0) saw_zero = 1;
        check(saw_zero, "R6 hit field wrapped to zero", int'(saw_zero), 1);

        // R1: reset in the middle of a pulse
        cur_req = "R1";
        comp_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(word_valid === 1'b0, "R1 valid during reset", int'(word_valid), 0);
        comp_in = 1'b0;
        rst = 1'b0;
        repeat (5) @(negedge clk);
        pulse(3, 6);
        check(hfield(acc_q[$]) == 1, "R1 first hit after reset", hfield(acc_q[$]), 1);
        check(wfield(acc_q[$]) == 3, "R1 width after reset", wfield(acc_q[$]), 3);

        checking = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule